// File: doc/BRIEF.md
# Presettable Up/Down Counter Stage

A single counting stage of `WIDTH` bits, 4 by default. On each rising clock edge it adds or subtracts one. A build parameter sets the count range: decimal digit (0..9) or full binary (0..2^WIDTH-1). An active-low enable gates counting. A direction input chooses up or down. An active-low preset input forces the count to the value on the data inputs at once, without waiting for a clock edge.

Two outputs support chaining. `maxMin` flags the last count in the current direction. `rippleN` repeats that flag as an active-low pulse that appears only while the clock is low. A multi-digit counter is built by running all stages from one clock and feeding each stage's `rippleN` into the next stage's `enN`.

Top module: `updown_counter`

## Requirements
- R1: With `loadN` high, `enN` low and `downUp` low, a rising clock edge adds one to `count`, except at the wrap described in R5/R6/R7.
- R2: With `loadN` high, `enN` low and `downUp` high, a rising clock edge subtracts one from `count`, except at the wrap described in R5/R6.
- R3: With `enN` high, clock edges leave `count` unchanged.
- R4: While `loadN` is low, `count` equals `data` immediately, whatever the clock level. Clock edges and `enN` have no effect while `loadN` is low.
- R5: Decimal range (`DECADE`=1): counting up from 9 gives 0, and counting down from 0 gives 9.
- R6: Binary range (`DECADE`=0): counting up from 15 gives 0, and counting down from 0 gives 15.
- R7: Decimal range with a preset value of 10..15: counting up gives 0, counting down subtracts one, and `maxMin` stays low.
- R8: `maxMin` is 1 exactly when (`downUp`=0 and `count` is the range maximum) or (`downUp`=1 and `count`=0). It follows `count` and `downUp` combinationally, whatever the level of `enN`.
- R9: `rippleN` is 0 exactly when `maxMin` is 1 and `clk` is low. Otherwise it is 1.
- R10: A change on `downUp` between clock edges does not alter `count`. The direction takes effect only at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| loadN | input | 1 | Active-low asynchronous preset |
| enN | input | 1 | Active-low count enable |
| downUp | input | 1 | 0 counts up, 1 counts down |
| data | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| maxMin | output | 1 | Terminal count for the current direction |
| rippleN | output | 1 | Active-low terminal pulse during the clock low phase |

## Verification
A wrong stored count, or a wrong next-value decode, shows on `count` right after the rising edge where it happens. Because `maxMin` and `rippleN` are decoded from that count, a wrong terminal value also appears on them in the same cycle. A chained pair makes any such error stick: a missed or extra terminal pulse puts the upper digit one count off for good, and comparing the two-digit value against a modulo-100 model catches it at the next sample. A sweep over every preset value in both directions, for both range settings, covers all next-value and terminal decodes in one step each.

// File: rtl/updown_cnt_pkg.sv
`timescale 1ns/1ps
package updown_cnt_pkg;
  // strobes from the control decode to the datapath
  typedef struct packed {
    logic load;   // preset active
    logic step;   // count on next edge
    logic down;   // direction of the step
  } cntStrobe_t;
endpackage

// File: rtl/cnt_ctrl.sv
`timescale 1ns/1ps
module cnt_ctrl
  import updown_cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             loadN,
  input  logic             enN,
  input  logic             downUp,
  input  logic [WIDTH-1:0] count,
  output cntStrobe_t       strobe,
  output logic             maxMin,
  output logic             rippleN
);
  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic atTop;
  logic atZero;

  always_comb begin
    strobe.load = ~loadN;
    strobe.step = ~enN;
    strobe.down = downUp;
  end

  assign atTop   = (count == TOP);
  assign atZero  = (count == '0);
  assign maxMin  = downUp ? atZero : atTop;
  assign rippleN = ~(maxMin & ~clk);

  // ripple pulse only in low phase, and it mirrors the terminal flag there
  AST_RIPPLE_LOW_PHASE: assert property (@(posedge clk) rippleN == !maxMin); // R9
  AST_RIPPLE_HIGH_IDLE: assert property (@(negedge clk) rippleN);            // R9
endmodule

// File: rtl/cnt_datapath.sv
`timescale 1ns/1ps
module cnt_datapath
  import updown_cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             loadN,
  input  cntStrobe_t       strobe,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] nextQ;

  generate
    if (DECADE) begin : gDecade
      always_comb begin
        if (strobe.down) nextQ = (q == '0) ? TOP : q - ONE;
        else             nextQ = (q >= TOP) ? '0 : q + ONE;
      end
    end else begin : gBinary
      always_comb nextQ = strobe.down ? q - ONE : q + ONE;
    end
  endgenerate

  always_ff @(posedge clk or negedge loadN) begin
    if (!loadN)           q <= data;
    else if (strobe.step) q <= nextQ;
  end

  assign count = strobe.load ? data : q;

  // assertion support: marks a preset seen since the previous edge
  logic loadTouched;
  always_ff @(posedge clk or negedge loadN) begin
    if (!loadN) loadTouched <= 1'b1;
    else        loadTouched <= 1'b0;
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!loadN)
    (strobe.step && !strobe.down && q < TOP) |=> (loadTouched || q == $past(q) + ONE)); // R1
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!loadN)
    (strobe.step && strobe.down && q != '0) |=> (loadTouched || q == $past(q) - ONE)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!loadN)
    (!strobe.step) |=> (loadTouched || $stable(q))); // R3

  generate
    if (DECADE) begin : gDecChk
      AST_WRAP_DEC_UP: assert property (@(posedge clk) disable iff (!loadN)
        (strobe.step && !strobe.down && q == TOP) |=> (loadTouched || q == '0)); // R5
      AST_WRAP_DEC_DOWN: assert property (@(posedge clk) disable iff (!loadN)
        (strobe.step && strobe.down && q == '0) |=> (loadTouched || q == TOP)); // R5
      AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!loadN)
        (strobe.step && !strobe.down && q > TOP) |=> (loadTouched || q == '0)); // R7
    end else begin : gBinChk
      AST_WRAP_BIN: assert property (@(posedge clk) disable iff (!loadN)
        (strobe.step && q == (strobe.down ? '0 : TOP)) |=>
        (loadTouched || q == ($past(strobe.down) ? TOP : '0))); // R6
    end
  endgenerate
endmodule

// File: rtl/updown_counter.sv
`timescale 1ns/1ps
module updown_counter
  import updown_cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             loadN,
  input  logic             enN,
  input  logic             downUp,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] count,
  output logic             maxMin,
  output logic             rippleN
);
  cntStrobe_t strobe;

  cnt_ctrl #(.WIDTH(WIDTH), .DECADE(DECADE)) uCtrl (
    .clk(clk), .loadN(loadN), .enN(enN), .downUp(downUp),
    .count(count), .strobe(strobe), .maxMin(maxMin), .rippleN(rippleN)
  );

  cnt_datapath #(.WIDTH(WIDTH), .DECADE(DECADE)) uData (
    .clk(clk), .loadN(loadN), .strobe(strobe), .data(data), .count(count)
  );

  AST_LOAD_WINS: assert property (@(posedge clk) !loadN |-> count == data); // R4
endmodule

// File: tb/tb_updown_counter.sv
`timescale 1ns/1ps
module tb_updown_counter;
  logic       clk = 1'b0;
  logic       loadN = 1'b0, enN = 1'b1, downUp = 1'b0;
  logic [3:0] data = 4'd0;
  logic [3:0] countDec, countBin;
  logic       mmDec, mmBin, rnDec, rnBin;

  // chained decimal pair
  logic       cLoadN = 1'b0, cDown = 1'b0;
  logic [3:0] loCount, hiCount;
  logic       loMM, loRN, hiMM, hiRN;
  logic       hiEnN = 1'b1;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;

  updown_counter #(.WIDTH(4), .DECADE(1'b1)) dut (
    .clk(clk), .loadN(loadN), .enN(enN), .downUp(downUp), .data(data),
    .count(countDec), .maxMin(mmDec), .rippleN(rnDec));
  updown_counter #(.WIDTH(4), .DECADE(1'b0)) dutBin (
    .clk(clk), .loadN(loadN), .enN(enN), .downUp(downUp), .data(data),
    .count(countBin), .maxMin(mmBin), .rippleN(rnBin));
  updown_counter #(.WIDTH(4), .DECADE(1'b1)) chainLo (
    .clk(clk), .loadN(cLoadN), .enN(1'b0), .downUp(cDown), .data(4'd0),
    .count(loCount), .maxMin(loMM), .rippleN(loRN));
  updown_counter #(.WIDTH(4), .DECADE(1'b1)) chainHi (
    .clk(clk), .loadN(cLoadN), .enN(hiEnN), .downUp(cDown), .data(4'd0),
    .count(hiCount), .maxMin(hiMM), .rippleN(hiRN));

  // ripple to enable path: open during clock low, closed while high (hold margin)
  always @(clk or loRN) if (!clk) hiEnN = loRN;

  function automatic int expNext(int v, bit down, bit dec);
    int top = dec ? 9 : 15;
    if (down) return (v == 0) ? top : v - 1;
    if (dec)  return (v >= 9) ? 0 : v + 1;
    return (v + 1) % 16;
  endfunction

  function automatic bit expMM(int v, bit down, bit dec);
    return down ? (v == 0) : (v == (dec ? 9 : 15));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic presetBoth(input int v);
    data = 4'(v); loadN = 1'b0; #0.5; loadN = 1'b1;
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int model;
    int vd, vb;
    string tagD, tagB;
    repeat (2) @(posedge clk);
    #1;
    chk("R4 reset preset dec", 8'(countDec), 8'd0);
    chk("R4 reset preset bin", 8'(countBin), 8'd0);
    // R4: data followed at once, edges and enable ignored while preset low
    data = 4'd5; #0.5;
    chk("R4 immediate", 8'(countDec), 8'd5);
    enN = 1'b0;
    @(posedge clk); #1;
    chk("R4 edge ignored", 8'(countDec), 8'd5);
    chk("R4 edge ignored bin", 8'(countBin), 8'd5);
    // R3: hold
    enN = 1'b1; loadN = 1'b1;
    repeat (2) begin
      @(posedge clk); #1;
      chk("R3 hold dec", 8'(countDec), 8'd5);
      chk("R3 hold bin", 8'(countBin), 8'd5);
    end
    // sweep every preset, both directions, both ranges
    for (int v = 0; v < 16; v++) begin
      for (int d = 0; d < 2; d++) begin
        downUp = d[0];
        presetBoth(v);
        enN = 1'b0; #0.2;
        chk("R4 preset value", 8'(countBin), 8'(v));
        chk(v > 9 ? "R7 decade flag" : "R8 decade flag", 8'(mmDec), 8'(expMM(v, d[0], 1'b1)));
        chk("R8 binary flag", 8'(mmBin), 8'(expMM(v, d[0], 1'b0)));
        @(negedge clk); #0.5;
        chk("R9 low phase dec", 8'(rnDec), 8'(!expMM(v, d[0], 1'b1)));
        chk("R9 low phase bin", 8'(rnBin), 8'(!expMM(v, d[0], 1'b0)));
        @(posedge clk); #1;
        tagD = (v > 9) ? "R7" : (expMM(v, d[0], 1'b1) ? "R5" : (d != 0 ? "R2" : "R1"));
        tagB = expMM(v, d[0], 1'b0) ? "R6" : (d != 0 ? "R2" : "R1");
        chk(tagD, 8'(countDec), 8'(expNext(v, d[0], 1'b1)));
        chk(tagB, 8'(countBin), 8'(expNext(v, d[0], 1'b0)));
        chk("R9 high phase", 8'(rnDec & rnBin), 8'd1);
        enN = 1'b1;
      end
    end
    // R10: direction toggles between edges do nothing until the edge
    downUp = 1'b0; presetBoth(3); enN = 1'b0;
    #0.3 downUp = 1'b1; #0.3 downUp = 1'b0; #0.3;
    chk("R10 mid-cycle", 8'(countDec), 8'd3);
    @(posedge clk); #1;
    chk("R10 up edge", 8'(countDec), 8'd4);
    downUp = 1'b1; #0.3;
    chk("R10 before edge", 8'(countDec), 8'd4);
    @(posedge clk); #1;
    chk("R10 down edge", 8'(countDec), 8'd3);
    // R8: flag independent of enable
    enN = 1'b1; downUp = 1'b0; presetBoth(9); #0.2;
    chk("R8 enN high dec max", 8'(mmDec), 8'd1);
    chk("R8 enN high bin not max", 8'(mmBin), 8'd0);
    downUp = 1'b1; #0.2;
    chk("R8 down at nine", 8'(mmDec), 8'd0);
    presetBoth(0); #0.2;
    chk("R8 down at zero", 8'(mmDec | (mmBin << 1)), 8'd3);
    // preset, five up, inhibit, five down
    for (int s = 0; s < 2; s++) begin
      int start = (s == 0) ? 7 : 13;
      downUp = 1'b0; presetBoth(start); enN = 1'b0;
      vd = start; vb = start;
      for (int k = 0; k < 11; k++) begin
        if (k == 5) enN = 1'b1;
        if (k == 6) begin enN = 1'b0; downUp = 1'b1; end
        @(posedge clk); #1;
        if (k != 5) begin
          vd = expNext(vd, downUp, 1'b1);
          vb = expNext(vb, downUp, 1'b0);
        end
        chk(k == 5 ? "R3 inhibit" : (k < 5 ? "R1 sequence" : "R2 sequence"), 8'(countDec), 8'(vd));
        chk(k == 5 ? "R3 inhibit bin" : "R6 sequence bin", 8'(countBin), 8'(vb));
      end
    end
    // chained two-digit counting
    cLoadN = 1'b1; model = 0;
    for (int k = 0; k < 270; k++) begin
      if (k == 120) cDown = 1'b1;
      @(posedge clk); #1;
      model = cDown ? (model + 99) % 100 : (model + 1) % 100;
      chk(cDown ? "R2 R9 chain down" : "R1 R9 chain up",
          8'(hiCount * 10 + loCount), 8'(model));
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule